// File: doc/BRIEF.md
# Per-Bit Configurable Bidirectional GPIO Port

This block controls one bidirectional I/O port of configurable width, eight pins by default. Each pin has its own output driver mode, picked from two configuration registers that give every bit two mode bits. For each pin the block drives an abstract pad model with five digital controls: an output enable, the value driven, a strong pull-up, a weak pull-up and a weak pull-down. It works these out from the pin's output latch, its mode bits and an alternate-function override. The pad's analog behaviour is not part of this block.

A peripheral such as a serial transmitter can take over a pin through the override. While the peripheral raises its per-bit active flag, its value replaces the latch value. When the flag drops, the latch controls the pin again. Raw pad inputs pass through a two-flop synchronizer and come back on a pin-read port. The latch contents come back on a separate latch-read port. Reset forces every latch to 1 and every pin to weak pull-up mode.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the edge sets every latch bit to 1, every `mode1` bit to 0 and every `mode2` bit to 1. After reset, with no override active, each pin shows `pad_oe`=0, `pad_weak_pu`=1 and every other control at 0.
- R2: When `lat_we` is high at a rising edge outside reset, `latch_q` equals `lat_wdata` after that edge. Without `lat_we`, `latch_q` keeps its value.
- R3: `m1_we` loads `m1_wdata` into the `mode1` register, and `m2_we` loads `m2_wdata` into the `mode2` register. Each write takes effect at the next rising edge. A pin's mode is {mode1[i],mode2[i]}: 00 open drain, 01 weak pull-up, 10 high impedance, 11 push-pull.
- R4: Open drain (00). When the effective value is 0, `pad_oe`=1 and `pad_out`=0. When it is 1, `pad_oe`=0. Both pull-ups stay off. `pad_weak_pd` equals bit i of the parameter `OD_PD_MASK`.
- R5: Weak pull-up (01). When the effective value is 0, `pad_oe`=1 and `pad_out`=0. When it is 1, `pad_oe`=0 and only `pad_weak_pu` is on.
- R6: High impedance (10). `pad_oe`, `pad_out`, `pad_strong_pu`, `pad_weak_pu` and `pad_weak_pd` are all 0, whatever the latch or the override holds.
- R7: Push-pull (11). `pad_oe`=1, `pad_out` equals the effective value, and `pad_strong_pu` equals the effective value. Both weak controls are 0.
- R8: A pin's effective value is `alt_val[i]` while `alt_act[i]` is 1, and the latch bit otherwise. The override acts combinationally and never changes `latch_q`.
- R9: `pin_rd` after a rising edge equals the `pad_in` value sampled two rising edges earlier. During reset the synchronizer stages load all ones.
- R10: A latch write strobe that arrives during reset is ignored: `latch_q` is all ones after every reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_we | input | 1 | Latch write strobe |
| lat_wdata | input | W | Latch write data |
| m1_we | input | 1 | Write strobe for the mode1 register |
| m1_wdata | input | W | Data for the mode1 register |
| m2_we | input | 1 | Write strobe for the mode2 register |
| m2_wdata | input | W | Data for the mode2 register |
| alt_act | input | W | Per-bit alternate-function active flag |
| alt_val | input | W | Per-bit alternate-function output value |
| pad_in | input | W | Raw pad input levels |
| pad_oe | output | W | Pad output enable |
| pad_out | output | W | Value driven while enabled |
| pad_strong_pu | output | W | Strong pull-up control |
| pad_weak_pu | output | W | Weak pull-up control |
| pad_weak_pd | output | W | Weak pull-down control |
| latch_q | output | W | Latch read-back |
| pin_rd | output | W | Synchronized pin read |

## Verification
The assertions assume that `rst_n` is held low for at least one rising edge before any other check applies. They also assume that every input changes only away from the rising edge, so each edge samples stable values. Outside reset they put no limit on strobes or override flags: any mix of simultaneous register writes and override activity is legal. The stimulus holds reset low for several cycles at the start and again at random points, and it drives every input at the falling edge. Directed phases sweep all four modes against both latch values, with and without an override.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    DRV_OPEN_DRAIN = 2'b00,
    DRV_WEAK_PU    = 2'b01,
    DRV_HIGH_Z     = 2'b10,
    DRV_PUSH_PULL  = 2'b11
  } drv_mode_e;

  typedef struct packed {
    logic oe;
    logic out;
    logic strong_pu;
    logic weak_pu;
    logic weak_pd;
  } pad_ctl_t;

  localparam int unsigned SYNC_DEPTH = 2;

  // Effective output value: alternate function wins only while active.
  function automatic logic pick_value(logic latch_bit, logic alt_on, logic alt_bit);
    return alt_on ? alt_bit : latch_bit;
  endfunction

  // Pad control decode for one pin.
  function automatic pad_ctl_t decode_pad(drv_mode_e mode, logic val, logic od_pd);
    pad_ctl_t c;
    c = '0;
    unique case (mode)
      DRV_OPEN_DRAIN: begin
        c.oe      = ~val;
        c.weak_pd = od_pd;
      end
      DRV_WEAK_PU: begin
        c.oe      = ~val;
        c.weak_pu = val;
      end
      DRV_HIGH_Z: c = '0;
      DRV_PUSH_PULL: begin
        c.oe        = 1'b1;
        c.out       = val;
        c.strong_pu = val;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat_we,
  input  logic [W-1:0] lat_wdata,
  input  logic         m1_we,
  input  logic [W-1:0] m1_wdata,
  input  logic         m2_we,
  input  logic [W-1:0] m2_wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] mode1_q,
  output logic [W-1:0] mode2_q
);

  localparam logic [W-1:0] ALL_ONE  = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZERO = {W{1'b0}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= ALL_ONE;
    end else if (lat_we) begin
      latch_q <= lat_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode1_q <= ALL_ZERO;
    end else if (m1_we) begin
      mode1_q <= m1_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode2_q <= ALL_ONE;
    end else if (m2_we) begin
      mode2_q <= m2_wdata;
    end
  end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stage[0] <= {W{1'b1}};
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stage[s] <= {W{1'b1}};
          else        stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign q = stage[DEPTH-1];

endmodule

// File: rtl/gpio_port_drv.sv
module gpio_port_drv
  import gpio_port_pkg::*;
#(
  parameter bit OD_PD = 1'b0
) (
  input  logic     mode1,
  input  logic     mode2,
  input  logic     latch_bit,
  input  logic     alt_on,
  input  logic     alt_bit,
  output logic     eff,
  output pad_ctl_t ctl
);

  drv_mode_e mode;

  always_comb begin
    mode = drv_mode_e'({mode1, mode2});
    eff  = pick_value(latch_bit, alt_on, alt_bit);
    ctl  = decode_pad(mode, eff, OD_PD);
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned  W          = 8,
  parameter logic [W-1:0] OD_PD_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat_we,
  input  logic [W-1:0] lat_wdata,
  input  logic         m1_we,
  input  logic [W-1:0] m1_wdata,
  input  logic         m2_we,
  input  logic [W-1:0] m2_wdata,
  input  logic [W-1:0] alt_act,
  input  logic [W-1:0] alt_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_strong_pu,
  output logic [W-1:0] pad_weak_pu,
  output logic [W-1:0] pad_weak_pd,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] pin_rd
);

  // Named internal state, brought out for the checker.
  logic [W-1:0] mode1_q;
  logic [W-1:0] mode2_q;
  logic [W-1:0] eff_val;

  gpio_port_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .lat_we    (lat_we),
    .lat_wdata (lat_wdata),
    .m1_we     (m1_we),
    .m1_wdata  (m1_wdata),
    .m2_we     (m2_we),
    .m2_wdata  (m2_wdata),
    .latch_q   (latch_q),
    .mode1_q   (mode1_q),
    .mode2_q   (mode2_q)
  );

  gpio_port_sync #(.W(W), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_rd)
  );

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      pad_ctl_t ctl;
      gpio_port_drv #(.OD_PD(OD_PD_MASK[i])) u_drv (
        .mode1     (mode1_q[i]),
        .mode2     (mode2_q[i]),
        .latch_bit (latch_q[i]),
        .alt_on    (alt_act[i]),
        .alt_bit   (alt_val[i]),
        .eff       (eff_val[i]),
        .ctl       (ctl)
      );
      assign pad_oe[i]        = ctl.oe;
      assign pad_out[i]       = ctl.out;
      assign pad_strong_pu[i] = ctl.strong_pu;
      assign pad_weak_pu[i]   = ctl.weak_pu;
      assign pad_weak_pd[i]   = ctl.weak_pd;
    end
  endgenerate

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lat_we,
  input logic [W-1:0] lat_wdata,
  input logic [W-1:0] alt_act,
  input logic [W-1:0] alt_val,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_strong_pu,
  input logic [W-1:0] pad_weak_pu,
  input logic [W-1:0] pad_weak_pd,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] pin_rd,
  input logic [W-1:0] mode1_q,
  input logic [W-1:0] mode2_q,
  input logic [W-1:0] eff_val
);

  logic       prev_rst = 1'b0;
  logic [1:0] up_cnt;

  always_ff @(posedge clk) prev_rst <= !rst_n;

  always_ff @(posedge clk) begin
    if (!rst_n)              up_cnt <= 2'd0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  wire [W-1:0] od_m  = ~mode1_q & ~mode2_q;
  wire [W-1:0] wpu_m = ~mode1_q &  mode2_q;
  wire [W-1:0] hiz_m =  mode1_q & ~mode2_q;
  wire [W-1:0] pp_m  =  mode1_q &  mode2_q;

  AST_RESET_LATCH_HIGH: assert property (@(posedge clk)
    prev_rst |-> (latch_q == {W{1'b1}})); // R10

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd1 && $past(lat_we)) |-> (latch_q == $past(lat_wdata))); // R2

  AST_OD_NO_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_strong_pu | pad_weak_pu | pad_out) & od_m) == '0); // R4

  AST_WEAK_PU_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_weak_pu & ~(wpu_m & latch_q & ~alt_act)) & ~(wpu_m & alt_act & alt_val)) == '0); // R5

  AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out | pad_strong_pu | pad_weak_pu | pad_weak_pd) & hiz_m) == '0); // R6

  AST_PP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pad_oe & pp_m) == '0) && ((pad_strong_pu & ~pp_m) == '0)); // R7

  AST_ALT_TAKES_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    ((eff_val ^ alt_val) & alt_act) == '0); // R8

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (pin_rd == $past(pad_in, 2))); // R9

endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lat_we        (lat_we),
  .lat_wdata     (lat_wdata),
  .alt_act       (alt_act),
  .alt_val       (alt_val),
  .pad_in        (pad_in),
  .pad_oe        (pad_oe),
  .pad_out       (pad_out),
  .pad_strong_pu (pad_strong_pu),
  .pad_weak_pu   (pad_weak_pu),
  .pad_weak_pd   (pad_weak_pd),
  .latch_q       (latch_q),
  .pin_rd        (pin_rd),
  .mode1_q       (mode1_q),
  .mode2_q       (mode2_q),
  .eff_val       (eff_val)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;

  localparam int W = 8;
  localparam logic [W-1:0] PD_MASK = 8'h0F;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lat_we = 1'b0, m1_we = 1'b0, m2_we = 1'b0;
  logic [W-1:0] lat_wdata = '0, m1_wdata = '0, m2_wdata = '0;
  logic [W-1:0] alt_act = '0, alt_val = '0, pad_in = '0;
  logic [W-1:0] pad_oe, pad_out, pad_strong_pu, pad_weak_pu, pad_weak_pd;
  logic [W-1:0] latch_q, pin_rd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model state
  logic [W-1:0] m_lat, m_m1, m_m2, m_s1, m_s2;

  always #5 clk = ~clk;

  gpio_port #(.W(W), .OD_PD_MASK(PD_MASK)) uut (
    .clk(clk), .rst_n(rst_n),
    .lat_we(lat_we), .lat_wdata(lat_wdata),
    .m1_we(m1_we), .m1_wdata(m1_wdata),
    .m2_we(m2_we), .m2_wdata(m2_wdata),
    .alt_act(alt_act), .alt_val(alt_val), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_strong_pu(pad_strong_pu),
    .pad_weak_pu(pad_weak_pu), .pad_weak_pd(pad_weak_pd),
    .latch_q(latch_q), .pin_rd(pin_rd)
  );

  // Expected {oe,out,strong,weak_pu,weak_pd} for one pin, from R4-R7.
  function automatic logic [4:0] want_ctl(logic a, logic b, logic v, logic pd);
    if (!a && !b) return {~v, 1'b0, 1'b0, 1'b0, pd};   // open drain
    if (!a &&  b) return {~v, 1'b0, 1'b0, v, 1'b0};    // weak pull-up
    if ( a && !b) return 5'b00000;                     // high impedance
    return {1'b1, v, v, 1'b0, 1'b0};                   // push-pull
  endfunction

  function automatic string req_of(logic a, logic b);
    if (!a && !b) return "R4";
    if (!a &&  b) return "R5";
    if ( a && !b) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Compare all outputs against the model (called away from the edge).
  task automatic check_all(string extra);
    for (int i = 0; i < W; i++) begin
      logic v;
      logic [4:0] got;
      v   = alt_act[i] ? alt_val[i] : m_lat[i];
      got = {pad_oe[i], pad_out[i], pad_strong_pu[i], pad_weak_pu[i], pad_weak_pd[i]};
      check(alt_act[i] ? "R8" : req_of(m_m1[i], m_m2[i]), 32'(got),
            32'(want_ctl(m_m1[i], m_m2[i], v, PD_MASK[i])), $sformatf("pin %0d ctl %s", i, extra));
    end
    check("R2", 32'(latch_q), 32'(m_lat), "latch read");
    check("R9", 32'(pin_rd), 32'(m_s2), "pin read");
  endtask

  // One clock: model updates at the edge, checks at the falling edge.
  task automatic tick();
    @(posedge clk);
    if (!rst_n) begin
      m_lat = '1; m_m1 = '0; m_m2 = '1; m_s1 = '1; m_s2 = '1;
    end else begin
      if (lat_we) m_lat = lat_wdata;
      if (m1_we)  m_m1  = m1_wdata;
      if (m2_we)  m_m2  = m2_wdata;
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
    @(negedge clk);
    check_all("");
  endtask

  task automatic idle();
    lat_we = 1'b0; m1_we = 1'b0; m2_we = 1'b0;
  endtask

  task automatic set_modes(logic [W-1:0] a, logic [W-1:0] b);
    m1_we = 1'b1; m1_wdata = a; m2_we = 1'b1; m2_wdata = b;
    tick();
    idle();
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_lat = '1; m_m1 = '0; m_m2 = '1; m_s1 = '1; m_s2 = '1;

    // R10: write strobe during reset is ignored
    rst_n = 1'b0;
    lat_we = 1'b1; lat_wdata = 8'h00;
    tick(); tick();
    check("R10", 32'(latch_q), 32'hFF, "latch during reset");
    idle();
    tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state, weak pull-up with latch high
    check("R1", 32'(pad_weak_pu), 32'hFF, "weak pu after reset");
    check("R1", 32'(pad_oe), 32'h00, "oe after reset");

    // R2: latch write lands at the next edge
    lat_we = 1'b1; lat_wdata = 8'hA5;
    tick();
    idle();
    check("R2", 32'(latch_q), 32'hA5, "latch after write");
    tick();
    check("R2", 32'(latch_q), 32'hA5, "latch held");

    // R3: mode sweep, every mode against both latch values
    set_modes(8'h00, 8'h00); tick();
    check("R4", 32'(pad_oe), 32'h5A, "od oe");
    check("R4", 32'(pad_weak_pd), 32'(PD_MASK), "od pulldown");
    set_modes(8'hFF, 8'h00); tick();
    check("R6", 32'(pad_oe | pad_weak_pu | pad_weak_pd | pad_strong_pu), 32'h0, "hiz quiet");
    set_modes(8'hFF, 8'hFF); tick();
    check("R7", 32'(pad_strong_pu), 32'hA5, "pp strong");
    check("R3", 32'(pad_oe), 32'hFF, "pp oe after mode write");
    set_modes(8'h0F, 8'h33); tick();

    // R8: override replaces latch only while active
    alt_act = 8'hFF; alt_val = 8'h3C;
    set_modes(8'hFF, 8'hFF);
    check("R8", 32'(pad_out), 32'h3C, "override value");
    check("R8", 32'(latch_q), 32'hA5, "latch untouched by override");
    alt_act = 8'h00;
    #1;
    check("R8", 32'(pad_out), 32'hA5, "override released");

    // R9: synchronizer latency with a directed pattern
    pad_in = 8'hC3; tick();
    check("R9", 32'(pin_rd), 32'(m_s2), "pin read first edge");
    tick();
    check("R9", 32'(pin_rd), 32'hC3, "pin read after two edges");

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      rst_n     = ($urandom_range(0, 99) != 0);
      lat_we    = ($urandom_range(0, 3) == 0);
      lat_wdata = W'($urandom);
      m1_we     = ($urandom_range(0, 7) == 0);
      m1_wdata  = W'($urandom);
      m2_we     = ($urandom_range(0, 7) == 0);
      m2_wdata  = W'($urandom);
      alt_act   = W'($urandom) & W'($urandom);
      alt_val   = W'($urandom);
      pad_in    = W'($urandom);
      tick();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule